// File: doc/BRIEF.md
# Packet Header Byte Stripper

This block sits on a byte-lane streaming path and removes a fixed number of leading payload bytes from every packet. It removes them by clearing their lane-enable bits only. The data word itself is never moved, and every surviving byte stays in its original lane. A downstream packer or gearbox compacts the stream later if needed.

Several instances can be placed in series, one per protocol layer. Each one drops its own layer's header length. An instance further down the chain may therefore receive beats whose lowest lanes were already emptied upstream. Only lanes that are still enabled count toward an instance's own strip length. The strip length and the lane count are fixed when the design is elaborated.

The handshake is a wire-through. The input beat is accepted exactly when the output beat is taken, and the block holds no data storage. Its only state is the count of bytes already removed from the current packet.

Top module: `hdrstrip`

## Requirements
- R1: `m_tdata`, `m_tlast` and `m_tvalid` equal `s_tdata`, `s_tlast` and `s_tvalid` in the same cycle. When the input is idle, the output is idle.
- R2: `s_tready` equals `m_tready` in the same cycle.
- R3: No output enable bit is ever set where the input enable bit is clear: `m_tkeep & ~s_tkeep == 0`.
- R4: Enabled lanes are counted in order through a packet. Within a beat, lane 0 (`s_tkeep[0]`, data bits 7:0) comes first, and beats follow in transfer order. The first `STRIP` enabled lanes of each packet are cleared, and every later enabled lane is passed with its bit set.
- R5: Lanes whose input enable bit is already 0 do not count toward `STRIP`. This holds wherever they sit in the beat, including holes between enabled lanes.
- R6: After a beat with `s_tlast` high is transferred, the next packet is stripped again from its first enabled lane.
- R7: A beat whose enable bits are all cleared (by stripping or on input) is still forwarded with `m_tvalid` high, an all-zero `m_tkeep`, and its `m_tlast` value.
- R8: A packet with fewer than `STRIP` enabled lanes leaves the output with every lane cleared. Its last beat still carries `m_tlast`, and the following packet is unaffected.
- R9: A beat offered with `m_tready` low does not advance the removal count. While such a beat is held unchanged, `m_tkeep` holds unchanged too.
- R10: After reset, the removal count is zero, even if reset arrives in the middle of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tdata | input | 8*NB | Input data, byte lane i in bits 8i+7:8i |
| s_tkeep | input | NB | Input lane enables |
| s_tlast | input | 1 | Input last beat of packet |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| m_tdata | output | 8*NB | Output data, unshifted |
| m_tkeep | output | NB | Output lane enables with stripped lanes cleared |
| m_tlast | output | 1 | Output last beat of packet |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |

## Verification
The bench drives several kinds of packet:
- Packets with every lane enabled, which place the strip boundary inside a beat.
- Packets whose leading lanes were already emptied, as after an upstream stage.
- Beats with alternating holes, which separate counting of enabled lanes from counting of lane positions.
- Packets shorter than the strip length, and beats with an all-zero enable mask and the last flag set.

Back-pressure stalls show whether the count advances only on transfers. A reset in the middle of a packet shows that the count starts again from zero. A long run of random masks, lengths and ready patterns is compared against a behavioural reference on every clock.

// File: rtl/hdrstrip_pkg.sv
package hdrstrip_pkg;
  // width able to hold any count up to max(a, b)
  function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return $clog2(m + 1);
  endfunction
endpackage

// File: rtl/hdrstrip_lanemask.sv
// Marks which enabled lanes of one beat fall inside the remaining strip budget.
module hdrstrip_lanemask #(
  parameter int unsigned NB = 64,
  parameter int unsigned CW = 7
) (
  input  logic [NB-1:0] keep,
  input  logic [CW-1:0] budget,
  output logic [NB-1:0] clr,
  output logic [CW-1:0] take
);
  // running count of enabled lanes below each lane position
  logic [CW-1:0] pre [NB+1];

  assign pre[0] = '0;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign pre[i+1] = pre[i] + CW'(keep[i]);
    assign clr[i]   = keep[i] & (pre[i] < budget);
  end

  assign take = (pre[NB] < budget) ? pre[NB] : budget;
endmodule

// File: rtl/hdrstrip_count.sv
// Per-packet count of lanes removed so far.
module hdrstrip_count #(
  parameter int unsigned STRIP = 42,
  parameter int unsigned CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer,
  input  logic          last,
  input  logic [CW-1:0] take,
  output logic [CW-1:0] budget
);
  logic [CW-1:0] removed_q;
  logic [CW-1:0] removed_d;
  logic          removed_en;

  always_comb begin
    removed_en = xfer;
    if (last) removed_d = '0;
    else      removed_d = removed_q + take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          removed_q <= '0;
    else if (removed_en) removed_q <= removed_d;
  end

  assign budget = CW'(STRIP) - removed_q;
endmodule

// File: rtl/hdrstrip.sv
module hdrstrip #(
  parameter int unsigned NB    = 64,
  parameter int unsigned STRIP = 42
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [8*NB-1:0] s_tdata,
  input  logic [NB-1:0]   s_tkeep,
  input  logic            s_tlast,
  input  logic            s_tvalid,
  output logic            s_tready,
  output logic [8*NB-1:0] m_tdata,
  output logic [NB-1:0]   m_tkeep,
  output logic            m_tlast,
  output logic            m_tvalid,
  input  logic            m_tready
);
  localparam int unsigned CW = hdrstrip_pkg::cnt_width(NB, STRIP);

  logic [CW-1:0] budget;
  logic [CW-1:0] take;
  logic [NB-1:0] clr;
  logic          xfer;

  assign xfer = s_tvalid & m_tready;

  hdrstrip_lanemask #(.NB(NB), .CW(CW)) u_mask (
    .keep   (s_tkeep),
    .budget (budget),
    .clr    (clr),
    .take   (take)
  );

  hdrstrip_count #(.STRIP(STRIP), .CW(CW)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .xfer   (xfer),
    .last   (s_tlast),
    .take   (take),
    .budget (budget)
  );

  assign s_tready = m_tready;
  assign m_tdata  = s_tdata;
  assign m_tlast  = s_tlast;
  assign m_tvalid = s_tvalid;
  assign m_tkeep  = s_tkeep & ~clr;
endmodule

// File: rtl/hdrstrip_chk.sv
module hdrstrip_chk #(
  parameter int unsigned NB    = 64,
  parameter int unsigned STRIP = 42
) (
  input logic            clk,
  input logic            rst_n,
  input logic [8*NB-1:0] s_tdata,
  input logic [NB-1:0]   s_tkeep,
  input logic            s_tlast,
  input logic            s_tvalid,
  input logic            s_tready,
  input logic [8*NB-1:0] m_tdata,
  input logic [NB-1:0]   m_tkeep,
  input logic            m_tlast,
  input logic            m_tvalid,
  input logic            m_tready
);
  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tdata == s_tdata) && (m_tlast == s_tlast) && (m_tvalid == s_tvalid));

  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_tready == m_tready);

  p_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tkeep & ~s_tkeep) == '0);

  p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(s_tkeep & ~m_tkeep) <= STRIP);

  p_fresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && m_tready && s_tlast) |=>
      (($countones(s_tkeep) < STRIP) || ($countones(s_tkeep & ~m_tkeep) == STRIP)));

  p_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tlast) |-> (m_tvalid && m_tlast));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && !m_tready) |=> (!$stable(s_tkeep) || $stable(m_tkeep)));
endmodule

bind hdrstrip hdrstrip_chk #(.NB(NB), .STRIP(STRIP)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tkeep(s_tkeep),
  .s_tlast(s_tlast), .s_tvalid(s_tvalid), .s_tready(s_tready),
  .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast),
  .m_tvalid(m_tvalid), .m_tready(m_tready)
);

// File: tb/tb_hdrstrip.sv
`timescale 1ns/1ps
module tb_hdrstrip;
  localparam int NB    = 8;
  localparam int STRIP = 10;

  logic            clk;
  logic            rst_n;
  logic [8*NB-1:0] s_tdata;
  logic [NB-1:0]   s_tkeep;
  logic            s_tlast;
  logic            s_tvalid;
  logic            s_tready;
  logic [8*NB-1:0] m_tdata;
  logic [NB-1:0]   m_tkeep;
  logic            m_tlast;
  logic            m_tvalid;
  logic            m_tready;

  int checks = 0;
  int errors = 0;
  int removed = 0;   // reference: live lanes removed in current packet
  bit done = 0;

  hdrstrip #(.NB(NB), .STRIP(STRIP)) dut (.*);

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference for the output mask of the beat now on the input
  function automatic logic [NB-1:0] ref_keep(input logic [NB-1:0] k);
    int r = removed;
    logic [NB-1:0] o = k;
    for (int i = 0; i < NB; i++)
      if (k[i] && r < STRIP) begin o[i] = 1'b0; r++; end
    return o;
  endfunction

  function automatic int live(input logic [NB-1:0] k);
    int n = 0;
    for (int i = 0; i < NB; i++) n += k[i];
    return n;
  endfunction

  // drive one cycle, compare at negedge, advance reference on transfer
  task automatic cyc(input bit v, input logic [NB-1:0] k, input bit l, input bit rdy,
                     input string req, input logic [NB-1:0] exp_k = '1, input bit use_exp = 0);
    logic [NB-1:0] e;
    @(posedge clk); #1;
    s_tvalid = v; s_tkeep = k; s_tlast = l; m_tready = rdy;
    s_tdata  = {$urandom, $urandom};
    @(negedge clk);
    e = ref_keep(k);
    chk(m_tvalid == v && m_tlast == l && m_tdata == s_tdata, {req, "/R1 pass"},
        {m_tvalid, m_tlast}, {v, l});
    chk(s_tready == rdy, {req, "/R2 ready"}, s_tready, rdy);
    if (v) begin
      chk(m_tkeep == e, {req, " keep"}, m_tkeep, e);
      if (use_exp) chk(m_tkeep == exp_k, {req, " keep abs"}, m_tkeep, exp_k);
    end
    if (v && rdy) begin
      if (l) removed = 0;
      else begin
        removed += live(k);
        if (removed > STRIP) removed = STRIP;
      end
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; s_tvalid = 0; s_tkeep = '0; s_tlast = 0; s_tdata = '0; m_tready = 1;
    #12;
    @(negedge clk);
    chk(m_tvalid == 0, "R10 reset idle", m_tvalid, 0);
    rst_n = 1;
    cyc(0, '0, 0, 1, "R1 idle");
    // R4 full lanes: 8 cleared, then 2, then none
    cyc(1, 8'hFF, 0, 1, "R4 b0", 8'h00, 1);
    cyc(1, 8'hFF, 0, 1, "R4 b1", 8'hFC, 1);
    cyc(1, 8'hFF, 1, 1, "R4 b2", 8'hFF, 1);
    // R5 pre-nulled leading lanes
    cyc(1, 8'hF0, 0, 1, "R5 b0", 8'h00, 1);
    cyc(1, 8'hFF, 0, 1, "R5 b1", 8'hC0, 1);
    cyc(1, 8'hFF, 1, 1, "R5 b2", 8'hFF, 1);
    // R5 holes
    cyc(1, 8'hAA, 0, 1, "R5 h0", 8'h00, 1);
    cyc(1, 8'h55, 0, 1, "R5 h1", 8'h00, 1);
    cyc(1, 8'h0F, 1, 1, "R5 h2", 8'h0C, 1);
    // R8 short packet then R6 fresh packet
    cyc(1, 8'hFF, 0, 1, "R8 s0", 8'h00, 1);
    cyc(1, 8'h01, 1, 1, "R8 s1", 8'h00, 1);
    cyc(1, 8'hFF, 0, 1, "R6 f0", 8'h00, 1);
    cyc(1, 8'hFF, 1, 1, "R6 f1", 8'hFC, 1);
    // R7 empty last beat
    cyc(1, 8'hFF, 0, 1, "R7 e0", 8'h00, 1);
    cyc(1, 8'h00, 1, 1, "R7 e1", 8'h00, 1);
    cyc(1, 8'hFF, 1, 1, "R7 e2", 8'h00, 1);
    // R9 stall: beat held, count must not advance
    cyc(1, 8'hFF, 0, 0, "R9 st0", 8'h00, 1);
    cyc(1, 8'hFF, 0, 0, "R9 st1", 8'h00, 1);
    cyc(1, 8'hFF, 0, 1, "R9 st2", 8'h00, 1);
    cyc(1, 8'hFF, 0, 0, "R9 st3", 8'hFC, 1);
    cyc(1, 8'hFF, 1, 1, "R9 st4", 8'hFC, 1);
    // R10 reset mid-packet
    cyc(1, 8'hFF, 0, 1, "R10 m0", 8'h00, 1);
    @(posedge clk); #1; rst_n = 0; s_tvalid = 0;
    @(posedge clk); #1; rst_n = 1; removed = 0;
    cyc(1, 8'hFF, 0, 1, "R10 m1", 8'h00, 1);
    cyc(1, 8'hFF, 1, 1, "R10 m2", 8'hFC, 1);
    // random traffic against the reference, R4
    for (int n = 0; n < 3000; n++)
      cyc($urandom_range(0, 3) != 0, NB'($urandom), $urandom_range(0, 4) == 0,
          $urandom_range(0, 3) != 0, "R4 rand");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule